// File: doc/BRIEF.md
# DVMA Page Table Translation Unit

This unit turns a 32-bit device virtual address into a 36-bit physical address. For each request it reads one 32-bit page table entry from memory. A device master hands over an address and a direction flag through a valid/ready handshake. The unit then forms the entry's memory address from the table base and the window-relative page index, and issues a single read on a fetch port. That port may answer after any number of cycles.

When the entry comes back, the unit checks its permission bits. If the access is allowed, it presents the physical address for one cycle. If it is not, it raises a one-cycle fault pulse. On a fault it also loads a status word and the page-aligned faulting address into two holding registers and sets a level interrupt. The surrounding register bank shows these to software and lowers the interrupt with an acknowledge strobe. The window start is a mask whose set bits mark the upper address bits that select the translation window. Those bits are cleared before indexing.

Top module: `dvma_xlate`

## Requirements
- R1: After reset, req_ready is 1, xl_valid, fault_valid and irq are 0, flt_status is 0x00800000 and flt_addr is 0.
- R2: On the cycle after a request is accepted, mem_rd_req is 1 for exactly one cycle, and mem_rd_addr equals (tbl_base << 4) + (((req_vaddr & ~win_start) >> 10) with bits 1:0 cleared), as a 36-bit sum.
- R3: req_ready is 0 from the cycle after acceptance until the cycle after the response is taken. Exactly one of xl_valid or fault_valid is then 1, for one cycle only, in the cycle after mem_rsp_valid.
- R4: The entry is valid when bit 1 is set, and writable when bit 2 is set. A valid entry, read by a read or by a write to a writable entry, gives xl_valid with xl_paddr = {entry[31:8], vaddr[11:0]}.
- R5: An entry with bit 1 clear gives fault_valid and no xl_valid, for both reads and writes.
- R6: A write to a valid entry with bit 2 clear faults. A read of the same entry translates.
- R7: On a fault, flt_status becomes 0xC0820000 for a write and 0xC0860000 for a read. The bits set are 31 (error), 30 (late error), 23 (reserved, always set), 17 (address valid) and, for reads, 18.
- R8: On a fault, flt_addr becomes the device address with bits 11:0 cleared. A later fault overwrites both registers completely and never sets bit 19 (multiple errors).
- R9: irq goes to 1 with the fault pulse and stays at 1 until irq_ack, which clears it on the next cycle. A successful translation changes neither irq, flt_status nor flt_addr.
- R10: xl_cacheable reports entry bit 7 with each translation. Entry bit 0 has no effect on the result.
- R11: A mem_rsp_valid while no fetch is outstanding produces no result pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Unit can accept a request |
| req_vaddr | input | 32 | Device virtual address |
| req_write | input | 1 | 1 = write access, 0 = read |
| tbl_base | input | 32 | Page table base (shifted left by 4) |
| win_start | input | 32 | Window start mask, bits cleared before indexing |
| mem_rd_req | output | 1 | Entry fetch request, one-cycle pulse |
| mem_rd_addr | output | 36 | Byte address of the entry |
| mem_rsp_valid | input | 1 | Fetched entry present |
| mem_rsp_data | input | 32 | Fetched entry |
| xl_valid | output | 1 | Translation result pulse |
| xl_paddr | output | 36 | Physical address |
| xl_cacheable | output | 1 | Cacheable flag of the entry |
| fault_valid | output | 1 | Fault pulse |
| flt_status | output | 32 | Captured fault status word |
| flt_addr | output | 32 | Captured faulting page address |
| irq | output | 1 | Fault interrupt, level |
| irq_ack | input | 1 | Lowers irq |

## Verification
The bench builds the unit with its default 32-bit device and 36-bit physical widths. It sweeps all eight power-of-two window sizes from 16 MB to 2 GB, all sixteen combinations of the four defined entry flag bits, and both directions, with fetch latencies from zero to three cycles. Every permission outcome is therefore checked against every window mask and entry index shift. Extra sequences cover a fault that stays unacknowledged across a later success and a second fault, and a stray response with no fetch outstanding.

// File: rtl/dvma_pkg.sv
package dvma_pkg;

    localparam int VA_W     = 32;
    localparam int PA_W     = 36;
    localparam int PTE_W    = 32;
    localparam int PAGE_SH  = 12;

    // entry flag positions
    localparam int PTE_VALID_B = 1;
    localparam int PTE_WRITE_B = 2;
    localparam int PTE_CACHE_B = 7;
    localparam int PTE_PFN_LO  = 8;

    // fault status bit positions
    localparam int FS_ERR_B  = 31;
    localparam int FS_LATE_B = 30;
    localparam int FS_RSV_B  = 23;
    localparam int FS_RD_B   = 18;
    localparam int FS_FAV_B  = 17;

    localparam logic [31:0] FS_RESET = 32'h1 << FS_RSV_B;

    typedef enum logic [0:0] {
        ST_IDLE  = 1'b0,
        ST_FETCH = 1'b1
    } xl_state_e;

    typedef struct packed {
        logic [VA_W-1:0] vaddr;
        logic            write;
    } xl_req_t;

    typedef struct packed {
        logic            ok;
        logic            cacheable;
        logic [PA_W-1:0] paddr;
    } xl_res_t;

    function automatic logic [31:0] fault_word(input logic is_read);
        logic [31:0] w;
        w = FS_RESET;
        w[FS_ERR_B]  = 1'b1;
        w[FS_LATE_B] = 1'b1;
        w[FS_FAV_B]  = 1'b1;
        w[FS_RD_B]   = is_read;
        return w;
    endfunction

endpackage

// File: rtl/dvma_pte_addr.sv
module dvma_pte_addr
    import dvma_pkg::*;
#(
    parameter int VW = VA_W,
    parameter int PW = PA_W,
    parameter int PS = PAGE_SH
) (
    input  logic [VW-1:0] base,
    input  logic [VW-1:0] win,
    input  logic [VW-1:0] vaddr,
    output logic [PW-1:0] ent_addr
);
    localparam int BSH = PW - VW;
    localparam int ISH = PS - 2;

    logic [VW-1:0] rel;
    logic [VW-1:0] idx;
    logic [PW-1:0] base_x;

    always_comb begin
        rel      = vaddr & ~win;
        idx      = rel >> ISH;
        idx[1:0] = 2'b00;
        base_x   = {base, {BSH{1'b0}}};
        ent_addr = base_x + PW'(idx);
    end
endmodule

// File: rtl/dvma_pte_check.sv
module dvma_pte_check
    import dvma_pkg::*;
#(
    parameter int VW = VA_W,
    parameter int PW = PA_W,
    parameter int EW = PTE_W,
    parameter int PS = PAGE_SH
) (
    input  logic [EW-1:0] entry,
    input  logic          is_write,
    input  logic [VW-1:0] vaddr,
    output xl_res_t       res
);
    logic unused_bits;
    assign unused_bits = ^{entry[PTE_PFN_LO-2:PTE_WRITE_B+1], entry[0], vaddr[VW-1:PS]};

    always_comb begin
        res.ok        = entry[PTE_VALID_B] && (!is_write || entry[PTE_WRITE_B]);
        res.cacheable = entry[PTE_CACHE_B];
        res.paddr     = {entry[EW-1:PTE_PFN_LO], vaddr[PS-1:0]};
    end
endmodule

// File: rtl/dvma_fault_rec.sv
module dvma_fault_rec
    import dvma_pkg::*;
#(
    parameter int VW = VA_W,
    parameter int PS = PAGE_SH
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          capture,
    input  logic          is_read,
    input  logic [VW-1:0] vaddr,
    input  logic          ack,
    output logic [31:0]   status,
    output logic [VW-1:0] addr,
    output logic          irq
);
    always_ff @(posedge clk) begin
        if (rst) begin
            status <= FS_RESET;
            addr   <= '0;
            irq    <= 1'b0;
        end else if (capture) begin
            status <= fault_word(is_read);
            addr   <= {vaddr[VW-1:PS], {PS{1'b0}}};
            irq    <= 1'b1;
        end else if (ack) begin
            irq    <= 1'b0;
        end
    end
endmodule

// File: rtl/dvma_xlate.sv
module dvma_xlate
    import dvma_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [VA_W-1:0]  req_vaddr,
    input  logic             req_write,
    input  logic [VA_W-1:0]  tbl_base,
    input  logic [VA_W-1:0]  win_start,
    output logic             mem_rd_req,
    output logic [PA_W-1:0]  mem_rd_addr,
    input  logic             mem_rsp_valid,
    input  logic [PTE_W-1:0] mem_rsp_data,
    output logic             xl_valid,
    output logic [PA_W-1:0]  xl_paddr,
    output logic             xl_cacheable,
    output logic             fault_valid,
    output logic [31:0]      flt_status,
    output logic [VA_W-1:0]  flt_addr,
    output logic             irq,
    input  logic             irq_ack
);
    xl_state_e       state_q;
    xl_req_t         req_q;
    logic            issue_q;
    logic [PA_W-1:0] ent_addr_d, ent_addr_q;
    xl_res_t         res_d;
    logic            ok_q, bad_q, cache_q;
    logic [PA_W-1:0] paddr_q;
    logic            accept, take;

    assign req_ready = (state_q == ST_IDLE);
    assign accept    = req_valid && req_ready;
    assign take      = (state_q == ST_FETCH) && mem_rsp_valid;

    dvma_pte_addr u_addr (
        .base     (tbl_base),
        .win      (win_start),
        .vaddr    (req_vaddr),
        .ent_addr (ent_addr_d)
    );

    dvma_pte_check u_check (
        .entry    (mem_rsp_data),
        .is_write (req_q.write),
        .vaddr    (req_q.vaddr),
        .res      (res_d)
    );

    dvma_fault_rec u_fault (
        .clk     (clk),
        .rst     (rst),
        .capture (take && !res_d.ok),
        .is_read (!req_q.write),
        .vaddr   (req_q.vaddr),
        .ack     (irq_ack),
        .status  (flt_status),
        .addr    (flt_addr),
        .irq     (irq)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= ST_IDLE;
            req_q      <= '0;
            issue_q    <= 1'b0;
            ent_addr_q <= '0;
            ok_q       <= 1'b0;
            bad_q      <= 1'b0;
            cache_q    <= 1'b0;
            paddr_q    <= '0;
        end else begin
            issue_q <= accept;
            ok_q    <= take && res_d.ok;
            bad_q   <= take && !res_d.ok;
            if (accept) begin
                state_q       <= ST_FETCH;
                req_q.vaddr   <= req_vaddr;
                req_q.write   <= req_write;
                ent_addr_q    <= ent_addr_d;
            end else if (take) begin
                state_q <= ST_IDLE;
            end
            if (take && res_d.ok) begin
                paddr_q <= res_d.paddr;
                cache_q <= res_d.cacheable;
            end
        end
    end

    assign mem_rd_req   = issue_q;
    assign mem_rd_addr  = ent_addr_q;
    assign xl_valid     = ok_q;
    assign fault_valid  = bad_q;
    assign xl_paddr     = paddr_q;
    assign xl_cacheable = cache_q;
endmodule

// File: rtl/dvma_xlate_chk.sv
module dvma_xlate_chk
    import dvma_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic            req_valid,
    input logic            req_ready,
    input logic            mem_rd_req,
    input logic            xl_valid,
    input logic            fault_valid,
    input logic [31:0]     flt_status,
    input logic [VA_W-1:0] flt_addr,
    input logic            irq,
    input logic            irq_ack
);
    p_issue_after_accept_r2: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> mem_rd_req);

    p_issue_single_r2: assert property (@(posedge clk) disable iff (rst)
        mem_rd_req |=> !mem_rd_req);

    p_busy_during_fetch_r3: assert property (@(posedge clk) disable iff (rst)
        mem_rd_req |-> !req_ready);

    p_one_result_r3: assert property (@(posedge clk) disable iff (rst)
        $onehot0({xl_valid, fault_valid}));

    p_pulse_short_r3: assert property (@(posedge clk) disable iff (rst)
        (xl_valid || fault_valid) |=> !(xl_valid || fault_valid));

    p_status_bits_r7: assert property (@(posedge clk) disable iff (rst)
        fault_valid |-> (flt_status[FS_ERR_B] && flt_status[FS_LATE_B]
                         && flt_status[FS_RSV_B] && flt_status[FS_FAV_B]));

    p_page_aligned_r8: assert property (@(posedge clk) disable iff (rst)
        fault_valid |-> (flt_addr[PAGE_SH-1:0] == '0));

    p_no_multi_r8: assert property (@(posedge clk) disable iff (rst)
        !flt_status[19]);

    p_irq_with_fault_r9: assert property (@(posedge clk) disable iff (rst)
        fault_valid |-> irq);

    p_irq_ack_r9: assert property (@(posedge clk) disable iff (rst)
        (irq_ack && !fault_valid && $past(!rst)) |=> (!irq || fault_valid));

    p_status_hold_r9: assert property (@(posedge clk) disable iff (rst)
        xl_valid |-> $stable(flt_status));
endmodule

bind dvma_xlate dvma_xlate_chk chk_i (
    .clk         (clk),
    .rst         (rst),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .mem_rd_req  (mem_rd_req),
    .xl_valid    (xl_valid),
    .fault_valid (fault_valid),
    .flt_status  (flt_status),
    .flt_addr    (flt_addr),
    .irq         (irq),
    .irq_ack     (irq_ack)
);

// File: tb/dvma_xlate_tb.sv
module dvma_xlate_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid, req_ready, req_write;
    logic [31:0] req_vaddr, tbl_base, win_start;
    logic        mem_rd_req;
    logic [35:0] mem_rd_addr;
    logic        mem_rsp_valid;
    logic [31:0] mem_rsp_data;
    logic        xl_valid, xl_cacheable, fault_valid, irq, irq_ack;
    logic [35:0] xl_paddr;
    logic [31:0] flt_status, flt_addr;

    int n_chk = 0;
    int n_err = 0;
    logic [31:0] exp_status;
    logic [31:0] exp_faddr;
    logic        exp_irq;

    always #(CLK_PERIOD/2) clk = ~clk;

    dvma_xlate dut_i (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_vaddr(req_vaddr), .req_write(req_write),
        .tbl_base(tbl_base), .win_start(win_start),
        .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
        .xl_valid(xl_valid), .xl_paddr(xl_paddr), .xl_cacheable(xl_cacheable),
        .fault_valid(fault_valid), .flt_status(flt_status), .flt_addr(flt_addr),
        .irq(irq), .irq_ack(irq_ack)
    );

    task automatic check(input string rq, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic run_xlate(input logic [31:0] va, input logic wr,
                             input logic [31:0] base, input logic [31:0] win,
                             input logic [31:0] ent, input int lat, input logic do_ack);
        logic [35:0] ea;
        logic [31:0] idx;
        logic        ok;
        idx      = (va & ~win) >> 10;
        idx[1:0] = 2'b00;
        ea       = {base, 4'b0000} + {4'b0000, idx};
        ok       = ent[1] && (!wr || ent[2]);

        req_valid = 1'b1; req_vaddr = va; req_write = wr;
        tbl_base = base; win_start = win;
        check("R3", "ready before accept", req_ready, 1);
        step();
        req_valid = 1'b0;
        check("R2", "fetch issued", mem_rd_req, 1);
        check("R2", "entry address", mem_rd_addr, ea);
        check("R3", "busy after accept", req_ready, 0);
        for (int i = 0; i < lat; i++) begin
            step();
            check("R2", "fetch pulse single", mem_rd_req, 0);
            check("R3", "busy while waiting", req_ready, 0);
            check("R3", "no early result", xl_valid | fault_valid, 0);
        end
        mem_rsp_valid = 1'b1; mem_rsp_data = ent;
        step();
        mem_rsp_valid = 1'b0;
        check("R3", "ready after response", req_ready, 1);
        if (ok) begin
            check("R4", "xl_valid", xl_valid, 1);
            check("R4", "no fault", fault_valid, 0);
            check("R4", "paddr", xl_paddr, {ent[31:8], va[11:0]});
            check("R10", "cacheable", xl_cacheable, ent[7]);
            check("R9", "status kept", flt_status, exp_status);
            check("R9", "addr kept", flt_addr, exp_faddr);
            check("R9", "irq kept", irq, exp_irq);
        end else begin
            check(ent[1] ? "R6" : "R5", "fault_valid", fault_valid, 1);
            check(ent[1] ? "R6" : "R5", "no xl_valid", xl_valid, 0);
            exp_status = wr ? 32'hC082_0000 : 32'hC086_0000;
            exp_faddr  = {va[31:12], 12'h000};
            exp_irq    = 1'b1;
            check("R7", "status word", flt_status, exp_status);
            check("R8", "fault addr", flt_addr, exp_faddr);
            check("R9", "irq raised", irq, 1);
        end
        step();
        check("R3", "pulse ends", xl_valid | fault_valid, 0);
        if (do_ack && exp_irq) begin
            irq_ack = 1'b1;
            step();
            irq_ack = 1'b0;
            exp_irq = 1'b0;
            check("R9", "irq cleared by ack", irq, 0);
            check("R9", "status after ack", flt_status, exp_status);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        rst = 1'b1; req_valid = 1'b0; req_vaddr = '0; req_write = 1'b0;
        tbl_base = '0; win_start = '0; mem_rsp_valid = 1'b0; mem_rsp_data = '0;
        irq_ack = 1'b0;
        exp_status = 32'h0080_0000; exp_faddr = '0; exp_irq = 1'b0;
        repeat (3) step();
        rst = 1'b0;
        step();
        check("R1", "ready", req_ready, 1);
        check("R1", "xl_valid", xl_valid, 0);
        check("R1", "fault_valid", fault_valid, 0);
        check("R1", "irq", irq, 0);
        check("R1", "status", flt_status, 32'h0080_0000);
        check("R1", "addr", flt_addr, 0);

        // R11: stray response while idle
        mem_rsp_valid = 1'b1; mem_rsp_data = 32'hFFFF_FF00;
        step();
        mem_rsp_valid = 1'b0;
        check("R11", "no pulse on stray response", xl_valid | fault_valid, 0);
        check("R11", "still idle", req_ready, 1);

        // sweep: window sizes x entry flags x direction
        for (int k = 0; k < 8; k++) begin
            for (int f = 0; f < 16; f++) begin
                for (int w = 0; w < 2; w++) begin
                    logic [31:0] win, va, base, ent;
                    logic [23:0] pfn;
                    win  = 32'hFFFF_FFFF << (24 + k);
                    va   = win | ((32'h5A3C_7000 ^ (k << 16) ^ (f << 12)) & ~win)
                         | 32'(f * 16 + w * 4 + 3);
                    base = 32'h0012_3400 + 32'(k * 256);
                    pfn  = 24'h9E_1000 + 24'(k * 273) + 24'(f);
                    ent  = {pfn, f[3], 4'b0000, f[2], f[1], f[0]};
                    run_xlate(va, w[0], base, win, ent, (k + f + w) % 4, 1'b1);
                end
            end
        end

        // R9/R8: fault left pending, success in between, then overwrite
        run_xlate(32'hFF12_3456, 1'b1, 32'h0001_0000, 32'hFF00_0000, 32'h1234_5600, 1, 1'b0);
        run_xlate(32'hFF45_6789, 1'b0, 32'h0001_0000, 32'hFF00_0000, 32'hABCD_EF06, 2, 1'b0);
        check("R9", "irq held across success", irq, 1);
        run_xlate(32'hFF77_7FFF, 1'b0, 32'h0001_0000, 32'hFF00_0000, 32'h0000_0085, 0, 1'b0);
        check("R8", "overwrite no multi bit", flt_status[19], 0);
        run_xlate(32'hFF00_0000, 1'b0, 32'h0001_0000, 32'hFF00_0000, 32'h0000_0001, 3, 1'b1);

        finish_run();
    end
endmodule